// File: doc/BRIEF.md
# Two-Channel Serial Interrupt Vector Controller

This block tracks receive, transmit and break interrupt state for a pair of serial channels, A and B. Each channel reports single-cycle event pulses: a received character became available, the transmit buffer went empty, the received character was taken, or the transmit buffer was written. The block also takes the per-channel interrupt mode settings, a status-high/low encoding select, and a per-channel "reset highest interrupt under service" command strobe from the register port.

From these inputs it keeps a pending flag and an under-service flag per interrupt source. It drives one active-high interrupt line that combines both channels. It also presents two read values. The first is a pending summary byte, readable through channel A. The second is a modified interrupt vector, readable through channel B, whose code names the last source that was latched or cleared.

A receive interrupt that is under service blocks a later transmit interrupt of the same channel from being latched. When both channels update the vector in the same cycle, channel A wins.

Top module: `dual_chan_irq_vec`

## Requirements
- R1: A channel requests an interrupt when any of these holds: its transmit interrupt is pending and its transmit enable is 1; its 2-bit receive mode is 01 or 10 and its receive interrupt is pending; or its break enable is 1 and its break status input is 1. Receive modes 00 and 11 never request.
- R2: `irq` is 1 exactly when at least one of the two channels requests, and it follows enable or break changes without waiting for a clock edge.
- R3: `pend_a` bit positions are: bit 5 channel A receive, bit 4 channel A transmit, bit 2 channel B receive, bit 1 channel B transmit. Bits 7, 6, 3 and 0 read 0. A receive event sets its bit. A transmit event sets its bit only if the event is latched and the channel's transmit enable is 1.
- R4: With `status_hi`=0 the vector codes are: no interrupt 0x06, receive A 0x0C, receive B 0x04, transmit A 0x08, transmit B 0x00.
- R5: With `status_hi`=1 the vector codes are: no interrupt 0x60, receive A 0x30, receive B 0x20, transmit A 0x10. Transmit B stays 0x00.
- R6: A transmit event is latched only if the channel has no receive interrupt under service. Latching marks transmit under service, may set the R3 bit, and loads the vector. The transmit interrupt becomes pending in either case, so R1 still applies to it.
- R7: The under-service reset command clears receive-under-service if it is set, and otherwise clears transmit-under-service. It changes neither `pend_a` nor `vec_b`.
- R8: A receive-taken or transmit-written pulse clears that source's pending state, its under-service flag and its `pend_a` bit, and loads the no-interrupt code for the current encoding.
- R9: After reset, `irq`=0, `pend_a`=0x00 and `vec_b`=0x06.
- R10: If both channels update the vector in the same cycle, channel A's code is loaded. The `pend_a` bits of both channels are updated.
- R11: Within one channel and one cycle, the order is: command, then clears, then the receive event, then the transmit event. A set therefore beats a clear, and a receive event blocks a transmit event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_mode_a | input | 2 | Receive interrupt mode, channel A |
| rx_mode_b | input | 2 | Receive interrupt mode, channel B |
| tx_ie | input | 2 | Transmit interrupt enable (bit 1 = A, bit 0 = B) |
| brk_ie | input | 2 | Break interrupt enable (bit 1 = A, bit 0 = B) |
| brk_stat | input | 2 | Break status level (bit 1 = A, bit 0 = B) |
| status_hi | input | 1 | Vector encoding select, 1 = status-high |
| rx_avail | input | 2 | Received character available pulse |
| tx_empty | input | 2 | Transmit buffer empty pulse |
| rx_taken | input | 2 | Received character read pulse |
| tx_written | input | 2 | Transmit buffer written pulse |
| ius_reset | input | 2 | Reset highest under-service command pulse |
| irq | output | 1 | Combined interrupt request |
| pend_a | output | 8 | Pending summary byte |
| vec_b | output | 8 | Modified interrupt vector |

## Verification
Two kinds of same-cycle overlap are provoked. In the first, both channels write the vector in one cycle: receive events on A and B together, and a receive event on B with a transmit event on A. The bench then checks that `pend_a` holds both bits and that `vec_b` carries channel A's code. In the second, one channel gets a receive-taken pulse and a receive-available pulse in the same cycle, and a transmit event arrives while a receive interrupt is still under service. The bench judges these by whether the set survives and whether the transmit bit and its vector stay out until the under-service command frees the channel.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int VEC_W  = 8;
  localparam int NCH    = 2;
  localparam int CH_B   = 0;
  localparam int CH_A   = 1;
  localparam int MODE_W = 2;

  typedef enum logic [1:0] {VK_NONE = 2'd0, VK_RX = 2'd1, VK_TX = 2'd2} vkind_e;

  typedef struct packed {
    logic   wr;
    vkind_e kind;
  } vload_t;

  // Vector code for a source kind, channel and encoding select
  function automatic logic [VEC_W-1:0] vec_code(vkind_e k, logic is_a, logic hi);
    logic [VEC_W-1:0] v;
    case (k)
      VK_RX:   v = is_a ? (hi ? 8'h30 : 8'h0C) : (hi ? 8'h20 : 8'h04);
      VK_TX:   v = is_a ? (hi ? 8'h10 : 8'h08) : 8'h00;
      default: v = hi ? 8'h60 : 8'h06;
    endcase
    return v;
  endfunction

  // Receive modes that produce a request
  function automatic logic rx_mode_on(logic [MODE_W-1:0] m);
    return (m == 2'b01) || (m == 2'b10);
  endfunction
endpackage

// File: rtl/sirq_chan_ctrl.sv
module sirq_chan_ctrl
  import sirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_set,
  input  logic              tx_set,
  input  logic              rx_clr,
  input  logic              tx_clr,
  input  logic              ius_cmd,
  input  logic              tx_en,
  input  logic [MODE_W-1:0] rx_mode,
  input  logic              brk_en,
  input  logic              brk_lvl,
  output logic              req,
  output logic              rx_flag,
  output logic              tx_flag,
  output logic              rx_ius,
  output logic              tx_ius,
  output vload_t            vload
);
  logic rx_pend_q, tx_pend_q, rx_ius_q, tx_ius_q, rx_flag_q, tx_flag_q;
  logic rx_pend_n, tx_pend_n, rx_ius_n, tx_ius_n, rx_flag_n, tx_flag_n;
  vload_t ld;

  // Ordered update: command, clears, receive set, transmit set
  always_comb begin
    rx_pend_n = rx_pend_q;
    tx_pend_n = tx_pend_q;
    rx_ius_n  = rx_ius_q;
    tx_ius_n  = tx_ius_q;
    rx_flag_n = rx_flag_q;
    tx_flag_n = tx_flag_q;
    ld.wr     = 1'b0;
    ld.kind   = VK_NONE;
    if (ius_cmd) begin
      if (rx_ius_n)      rx_ius_n = 1'b0;
      else if (tx_ius_n) tx_ius_n = 1'b0;
    end
    if (tx_clr) begin
      tx_pend_n = 1'b0;
      tx_ius_n  = 1'b0;
      tx_flag_n = 1'b0;
      ld.wr     = 1'b1;
      ld.kind   = VK_NONE;
    end
    if (rx_clr) begin
      rx_pend_n = 1'b0;
      rx_ius_n  = 1'b0;
      rx_flag_n = 1'b0;
      ld.wr     = 1'b1;
      ld.kind   = VK_NONE;
    end
    if (rx_set) begin
      rx_pend_n = 1'b1;
      rx_ius_n  = 1'b1;
      rx_flag_n = 1'b1;
      ld.wr     = 1'b1;
      ld.kind   = VK_RX;
    end
    if (tx_set) begin
      tx_pend_n = 1'b1;
      if (!rx_ius_n) begin
        tx_ius_n = 1'b1;
        if (tx_en) tx_flag_n = 1'b1;
        ld.wr   = 1'b1;
        ld.kind = VK_TX;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_pend_q <= 1'b0;
      tx_pend_q <= 1'b0;
      rx_ius_q  <= 1'b0;
      tx_ius_q  <= 1'b0;
      rx_flag_q <= 1'b0;
      tx_flag_q <= 1'b0;
    end else begin
      rx_pend_q <= rx_pend_n;
      tx_pend_q <= tx_pend_n;
      rx_ius_q  <= rx_ius_n;
      tx_ius_q  <= tx_ius_n;
      rx_flag_q <= rx_flag_n;
      tx_flag_q <= tx_flag_n;
    end
  end

  assign req = (tx_en & tx_pend_q) | (rx_mode_on(rx_mode) & rx_pend_q) | (brk_en & brk_lvl);
  assign rx_flag = rx_flag_q;
  assign tx_flag = tx_flag_q;
  assign rx_ius  = rx_ius_q;
  assign tx_ius  = tx_ius_q;
  assign vload   = ld;
endmodule

// File: rtl/sirq_vec_reg.sv
module sirq_vec_reg
  import sirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             status_hi,
  input  vload_t           ld_a,
  input  vload_t           ld_b,
  output logic [VEC_W-1:0] vec
);
  logic [VEC_W-1:0] vec_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        vec_q <= vec_code(VK_NONE, 1'b0, 1'b0);
    else if (ld_a.wr)  vec_q <= vec_code(ld_a.kind, 1'b1, status_hi);
    else if (ld_b.wr)  vec_q <= vec_code(ld_b.kind, 1'b0, status_hi);
  end

  assign vec = vec_q;
endmodule

// File: rtl/sirq_merge.sv
module sirq_merge
  import sirq_pkg::*;
(
  input  logic [NCH-1:0]   chan_req,
  input  logic [NCH-1:0]   rx_flag,
  input  logic [NCH-1:0]   tx_flag,
  output logic             irq,
  output logic [VEC_W-1:0] pend
);
  assign irq  = |chan_req;
  assign pend = {2'b00, rx_flag[CH_A], tx_flag[CH_A], 1'b0,
                 rx_flag[CH_B], tx_flag[CH_B], 1'b0};
endmodule

// File: rtl/dual_chan_irq_vec.sv
module dual_chan_irq_vec
  import sirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rx_mode_a,
  input  logic [1:0] rx_mode_b,
  input  logic [1:0] tx_ie,
  input  logic [1:0] brk_ie,
  input  logic [1:0] brk_stat,
  input  logic       status_hi,
  input  logic [1:0] rx_avail,
  input  logic [1:0] tx_empty,
  input  logic [1:0] rx_taken,
  input  logic [1:0] tx_written,
  input  logic [1:0] ius_reset,
  output logic       irq,
  output logic [7:0] pend_a,
  output logic [7:0] vec_b
);
  logic [NCH-1:0]    chan_req, rx_flag, tx_flag, rx_ius, tx_ius;
  logic [MODE_W-1:0] mode_sel [NCH];
  vload_t            vload [NCH];

  assign mode_sel[CH_A] = rx_mode_a;
  assign mode_sel[CH_B] = rx_mode_b;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    sirq_chan_ctrl u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .rx_set  (rx_avail[c]),
      .tx_set  (tx_empty[c]),
      .rx_clr  (rx_taken[c]),
      .tx_clr  (tx_written[c]),
      .ius_cmd (ius_reset[c]),
      .tx_en   (tx_ie[c]),
      .rx_mode (mode_sel[c]),
      .brk_en  (brk_ie[c]),
      .brk_lvl (brk_stat[c]),
      .req     (chan_req[c]),
      .rx_flag (rx_flag[c]),
      .tx_flag (tx_flag[c]),
      .rx_ius  (rx_ius[c]),
      .tx_ius  (tx_ius[c]),
      .vload   (vload[c])
    );
  end

  sirq_vec_reg u_vec (
    .clk       (clk),
    .rst_n     (rst_n),
    .status_hi (status_hi),
    .ld_a      (vload[CH_A]),
    .ld_b      (vload[CH_B]),
    .vec       (vec_b)
  );

  sirq_merge u_merge (
    .chan_req (chan_req),
    .rx_flag  (rx_flag),
    .tx_flag  (tx_flag),
    .irq      (irq),
    .pend     (pend_a)
  );
endmodule

// File: rtl/sirq_checker.sv
module sirq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] rx_avail,
  input logic [1:0] tx_empty,
  input logic [1:0] rx_taken,
  input logic [1:0] tx_written,
  input logic [1:0] ius_reset,
  input logic [1:0] rx_ius,
  input logic [1:0] tx_ius,
  input logic [1:0] rx_flag,
  input logic [7:0] vec_b
);
  for (genvar c = 0; c < 2; c++) begin : g_chk
    assert_tx_latch_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_ius[c]) |-> !rx_ius[c]);
    assert_ius_rx_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ius_reset[c] && rx_ius[c] && !rx_avail[c]) |=> !rx_ius[c]);
    assert_ius_tx_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ius_reset[c] && rx_ius[c] && tx_ius[c] && !tx_written[c]) |=> tx_ius[c]);
    assert_clear_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_taken[c] && !rx_avail[c]) |=> (!rx_flag[c] && !rx_ius[c]));
    assert_rx_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_avail[c] |=> (rx_flag[c] && rx_ius[c]));
    assert_tx_any_free_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_empty[c] && rx_avail[c]) |=> !$rose(tx_ius[c]));
  end

  assert_vec_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_b inside {8'h06, 8'h0C, 8'h04, 8'h08, 8'h00, 8'h60, 8'h30, 8'h20, 8'h10});
endmodule

bind dual_chan_irq_vec sirq_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_avail   (rx_avail),
  .tx_empty   (tx_empty),
  .rx_taken   (rx_taken),
  .tx_written (tx_written),
  .ius_reset  (ius_reset),
  .rx_ius     (rx_ius),
  .tx_ius     (tx_ius),
  .rx_flag    (rx_flag),
  .vec_b      (vec_b)
);

// File: tb/dual_chan_irq_vec_test.sv
module dual_chan_irq_vec_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] rx_mode_a = 2'b00, rx_mode_b = 2'b00;
  logic [1:0] tx_ie = 2'b00, brk_ie = 2'b00, brk_stat = 2'b00;
  logic       status_hi = 1'b0;
  logic [1:0] rx_avail = 2'b00, tx_empty = 2'b00, rx_taken = 2'b00;
  logic [1:0] tx_written = 2'b00, ius_reset = 2'b00;
  logic       irq;
  logic [7:0] pend_a, vec_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic   irq;
    logic [7:0] pend;
    logic [7:0] vec;
    string  tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  dual_chan_irq_vec uut (
    .clk(clk), .rst_n(rst_n), .rx_mode_a(rx_mode_a), .rx_mode_b(rx_mode_b),
    .tx_ie(tx_ie), .brk_ie(brk_ie), .brk_stat(brk_stat), .status_hi(status_hi),
    .rx_avail(rx_avail), .tx_empty(tx_empty), .rx_taken(rx_taken),
    .tx_written(tx_written), .ius_reset(ius_reset),
    .irq(irq), .pend_a(pend_a), .vec_b(vec_b)
  );

  // Monitor: compare expectations away from the rising edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (irq !== e.irq || pend_a !== e.pend || vec_b !== e.vec) begin
        errors++;
        $display("FAIL %s: got irq=%b pend=%h vec=%h, expected irq=%b pend=%h vec=%h",
                 e.tag, irq, pend_a, vec_b, e.irq, e.pend, e.vec);
      end
    end
  end

  // Driver: one cycle of event pulses (bit1 = A, bit0 = B), then expectation
  task automatic cyc(input logic [1:0] rs, input logic [1:0] ts, input logic [1:0] rc,
                     input logic [1:0] tc, input logic [1:0] ic,
                     input logic ei, input logic [7:0] ep, input logic [7:0] ev,
                     input string tag);
    exp_t e;
    @(negedge clk); #1;
    rx_avail = rs; tx_empty = ts; rx_taken = rc; tx_written = tc; ius_reset = ic;
    @(posedge clk); #1;
    rx_avail = 0; tx_empty = 0; rx_taken = 0; tx_written = 0; ius_reset = 0;
    e.irq = ei; e.pend = ep; e.vec = ev; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic cfg_slot();
    @(negedge clk); #1;
  endtask

  initial begin
    int n = 0;
    while (!done && n < 20000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cyc(0, 0, 0, 0, 0, 0, 8'h00, 8'h06, "R9 reset state");

    // R1/R3/R4: receive A, status low
    cfg_slot(); rx_mode_a = 2'b01;
    cyc(2'b10, 0, 0, 0, 0, 1, 8'h20, 8'h0C, "R3 R4 rx A latch");
    cyc(0, 0, 2'b10, 0, 0, 0, 8'h00, 8'h06, "R8 rx A cleared");

    // R5: status high, receive B mode 10
    cfg_slot(); status_hi = 1'b1; rx_mode_b = 2'b10;
    cyc(2'b01, 0, 0, 0, 0, 1, 8'h04, 8'h20, "R5 rx B high code");
    cyc(0, 0, 2'b01, 0, 0, 0, 8'h00, 8'h60, "R5 R8 none high code");
    // R1: mode 11 never requests
    cfg_slot(); rx_mode_b = 2'b11;
    cyc(2'b01, 0, 0, 0, 0, 0, 8'h04, 8'h20, "R1 mode 11 no request");
    cyc(0, 0, 2'b01, 0, 0, 0, 8'h00, 8'h60, "R8 rx B cleared");
    // R5: transmit A high
    cfg_slot(); tx_ie = 2'b10;
    cyc(0, 2'b10, 0, 0, 0, 1, 8'h10, 8'h10, "R5 tx A high code");
    cyc(0, 0, 0, 2'b10, 0, 0, 8'h00, 8'h60, "R8 tx A cleared");

    // R4/R3: transmit B with enable off, then enable on
    cfg_slot(); status_hi = 1'b0;
    cyc(0, 2'b01, 0, 0, 0, 0, 8'h00, 8'h00, "R3 R4 tx B disabled no bit");
    cfg_slot(); tx_ie = 2'b11;
    cyc(0, 0, 0, 0, 0, 1, 8'h00, 8'h00, "R2 tx B enable raises irq");
    cyc(0, 0, 0, 2'b01, 0, 0, 8'h00, 8'h06, "R8 tx B cleared");

    // R6/R7: transmit blocked while receive under service
    cyc(2'b10, 0, 0, 0, 0, 1, 8'h20, 8'h0C, "R6 rx A under service");
    cyc(0, 2'b10, 0, 0, 0, 1, 8'h20, 8'h0C, "R6 tx A not latched");
    cyc(0, 0, 0, 0, 2'b10, 1, 8'h20, 8'h0C, "R7 command leaves bits and vector");
    cyc(0, 2'b10, 0, 0, 0, 1, 8'h30, 8'h08, "R6 R7 tx A latched after command");
    cyc(0, 0, 2'b10, 2'b10, 0, 0, 8'h00, 8'h06, "R8 both A cleared");

    // R10: both channels in one cycle
    cfg_slot(); rx_mode_b = 2'b01;
    cyc(2'b11, 0, 0, 0, 0, 1, 8'h24, 8'h0C, "R10 rx A and B, A wins");
    cyc(0, 0, 2'b10, 0, 0, 1, 8'h04, 8'h06, "R2 channel B alone keeps irq");
    cyc(0, 0, 2'b01, 0, 0, 0, 8'h00, 8'h06, "R8 rx B cleared");
    cyc(2'b01, 2'b10, 0, 0, 0, 1, 8'h14, 8'h08, "R10 tx A beats rx B");
    cyc(0, 0, 2'b01, 2'b10, 0, 0, 8'h00, 8'h06, "R10 cleanup");

    // R11: set beats clear; receive blocks transmit in the same cycle
    cyc(2'b10, 0, 2'b10, 0, 0, 1, 8'h20, 8'h0C, "R11 set beats clear");
    cyc(0, 0, 2'b10, 0, 0, 0, 8'h00, 8'h06, "R11 cleanup");
    cyc(2'b10, 2'b10, 0, 0, 0, 1, 8'h20, 8'h0C, "R11 rx blocks same-cycle tx");
    cyc(0, 0, 2'b10, 2'b10, 0, 0, 8'h00, 8'h06, "R11 cleanup two");

    // R1: break request
    cfg_slot(); brk_ie = 2'b10; brk_stat = 2'b10;
    cyc(0, 0, 0, 0, 0, 1, 8'h00, 8'h06, "R1 break raises irq");
    cfg_slot(); brk_ie = 2'b00;
    cyc(0, 0, 0, 0, 0, 0, 8'h00, 8'h06, "R1 break disabled");

    @(negedge clk); @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule